// File: doc/BRIEF.md
# Wiegand Bit-Stream Receiver

This block takes a Wiegand stream from a card reader on two active-low lines. The first line, `line_and`, carries the logical AND of the reader's two data wires. The second line, `line_one`, carries the reader's "one" wire alone. A bit is taken each time `line_and` goes from high to low. The level of `line_one` in that same cycle gives the bit's value. The incoming stream has no timing rules to meet: pulse width and gap length do not matter, only the edge and the sampled level.

Each bit becomes one byte on a write-style output, written as the ASCII digit `'0'` or `'1'`. Parity, format decoding and frame length are left to the consumer, so only raw bits come out. A frame ends when the line has been idle for longer than a programmable number of microseconds. A one-cycle `frame_done` pulse marks this. If `auto_close` is set, the receiver then shuts itself until software sends a `rearm` pulse.

Top module: `wiegand_rx`

## Requirements
- R1: A bit is registered only on a high-to-low transition of `line_and`, after a two-stage synchronizer. Each transition yields exactly one `out_valid` pulse lasting one cycle.
- R2: When `line_one` is high in the edge cycle, the output byte is 0x30 (`'0'`). When `line_one` is low in that cycle, the byte is 0x31 (`'1'`).
- R3: While `out_valid` is high, `out_data` is always 0x30 or 0x31.
- R4: Bits are decoded correctly for any pulse width and gap, down to two clock cycles per level.
- R5: `frame_done` pulses for one cycle exactly `idle_limit * CLK_PER_TICK` clock cycles after the `out_valid` of the last bit, provided no further bit arrives in that time. It pulses once per frame.
- R6: `frame_done` never fires when no bit has been received since the receiver last opened.
- R7: When `idle_limit` is 0, the timeout is disabled and `frame_done` never fires.
- R8: With `auto_close` high, `rx_open` drops after `frame_done`. Edges are then ignored until a `rearm` pulse reopens the receiver.
- R9: With `auto_close` low, the receiver stays open after `frame_done`.
- R10: A bit whose edge cycle sees `out_ready` low is dropped, with no `out_valid`. It sets the sticky `overflow` flag, which only `rearm` or reset clears.
- R11: While `en` is low, `rx_open` is low and no bits are delivered.
- R12: After reset, `out_valid`, `frame_done` and `overflow` are 0, and `rx_open` follows `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Receiver enable |
| auto_close | input | 1 | Close the receiver when the frame timeout expires |
| rearm | input | 1 | Pulse: reopen after auto-close and clear overflow |
| idle_limit | input | IDLE_W | Frame timeout in microsecond ticks; 0 disables it |
| line_and | input | 1 | AND of both reader data wires, active low |
| line_one | input | 1 | Reader "one" wire, active low |
| out_ready | input | 1 | Consumer can accept a byte this cycle |
| out_valid | output | 1 | Byte write strobe |
| out_data | output | 8 | ASCII digit 0x30 or 0x31 |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| overflow | output | 1 | Sticky: a bit was dropped |
| rx_open | output | 1 | Receiver currently accepts bits |

## Verification
The bench builds the block with `CLK_PER_TICK` = 4 and `IDLE_W` = 12. A timeout of a few tens of microsecond ticks is then only a few hundred cycles long. This lets several random frames, the exact timeout distance, auto-close and rearm all run in a short time. Random pulse widths and gaps stay well below the timeout, so any premature `frame_done` shows up. A directed frame runs at the minimum two-cycle levels, and the constant values check the disabled timeout.

// File: rtl/wg_pkg.sv
package wg_pkg;
   localparam logic [7:0] WG_ASCII_ZERO = 8'h30;

   function automatic logic [7:0] wg_digit(input logic b);
      return WG_ASCII_ZERO | {7'd0, b};
   endfunction
endpackage

// File: rtl/wg_sync.sv
module wg_sync #(
   parameter int STAGES = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= din;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= RESET_VAL;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/wg_edge.sv
module wg_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_and,
   input  logic line_one,
   output logic fall,
   output logic bit_val
);
   logic and_s, one_s, and_prev;

   wg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync_and (
      .clk(clk), .rst_n(rst_n), .din(line_and), .dout(and_s));
   wg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync_one (
      .clk(clk), .rst_n(rst_n), .din(line_one), .dout(one_s));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) and_prev <= 1'b1;
      else        and_prev <= and_s;

   assign fall    = and_prev & ~and_s;
   assign bit_val = ~one_s;   // one-wire low means data 1

   AST_FALL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);   // R1
endmodule

// File: rtl/wg_tick.sv
module wg_tick #(
   parameter int DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   generate
      if (DIV < 2) begin : g_bad_div
         $error("wg_tick: DIV must be at least 2");
      end
   endgenerate

   localparam int CW = $clog2(DIV);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   assign tick = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)              cnt <= '0;
      else if (restart || tick) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
endmodule

// File: rtl/wg_idle.sv
module wg_idle #(
   parameter int IDLE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open,
   input  logic              hit,
   input  logic              tick,
   input  logic [IDLE_W-1:0] limit,
   output logic              done
);
   logic              armed;
   logic [IDLE_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!open) begin
            armed <= 1'b0;
            cnt   <= '0;
         end else if (hit) begin
            armed <= 1'b1;
            cnt   <= '0;
         end else if (armed && (limit != '0) && tick) begin
            if (cnt == limit - 1'b1) begin
               done  <= 1'b1;
               armed <= 1'b0;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end

   AST_DONE_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(limit) != '0));   // R7
   AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);   // R5
endmodule

// File: rtl/wiegand_rx.sv
module wiegand_rx
   import wg_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int CLK_PER_TICK = 125,
   parameter int IDLE_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              auto_close,
   input  logic              rearm,
   input  logic [IDLE_W-1:0] idle_limit,
   input  logic              line_and,
   input  logic              line_one,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              frame_done,
   output logic              overflow,
   output logic              rx_open
);
   generate
      if (IDLE_W < 1) begin : g_bad_w
         $error("wiegand_rx: IDLE_W must be positive");
      end
   endgenerate

   logic fall, bit_val, tick, closed, hit;

   wg_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
      .clk(clk), .rst_n(rst_n), .line_and(line_and), .line_one(line_one),
      .fall(fall), .bit_val(bit_val));

   assign rx_open = en & ~closed;
   assign hit     = fall & rx_open;

   wg_tick #(.DIV(CLK_PER_TICK)) i_tick (
      .clk(clk), .rst_n(rst_n), .restart(hit), .tick(tick));

   wg_idle #(.IDLE_W(IDLE_W)) i_idle (
      .clk(clk), .rst_n(rst_n), .open(rx_open), .hit(hit), .tick(tick),
      .limit(idle_limit), .done(frame_done));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                          closed <= 1'b0;
      else if (rearm)                      closed <= 1'b0;
      else if (frame_done && auto_close)   closed <= 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                          overflow <= 1'b0;
      else if (rearm)                      overflow <= 1'b0;
      else if (hit && !out_ready)          overflow <= 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= WG_ASCII_ZERO;
      end else begin
         out_valid <= hit & out_ready;
         if (hit && out_ready) out_data <= wg_digit(bit_val);
      end

   AST_ASCII_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data == 8'h30 || out_data == 8'h31));   // R3
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);   // R1
   AST_OUT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(rx_open));   // R11
   AST_AUTO_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && auto_close && !rearm) |=> !rx_open);   // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !rearm) |=> overflow);   // R10
endmodule

// File: tb/test_wiegand_rx.sv
module test_wiegand_rx;
   localparam int P = 4;
   localparam int W = 12;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, auto_close = 1'b0, rearm = 1'b0;
   logic line_and = 1'b1, line_one = 1'b1, out_ready = 1'b1;
   logic [W-1:0] idle_limit = W'(50);
   logic out_valid, frame_done, overflow, rx_open;
   logic [7:0] out_data;

   wiegand_rx #(.SYNC_STAGES(2), .CLK_PER_TICK(P), .IDLE_W(W)) i_wiegand_rx (
      .clk(clk), .rst_n(rst_n), .en(en), .auto_close(auto_close), .rearm(rearm),
      .idle_limit(idle_limit), .line_and(line_and), .line_one(line_one),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .frame_done(frame_done), .overflow(overflow), .rx_open(rx_open));

   always #4 clk = ~clk;   // 125 MHz

   int cyc = 0;
   always @(posedge clk) cyc++;

   int n_chk = 0, n_bad = 0;
   logic [7:0] rxq[$];
   int last_v = 0, done_n = 0, done_gap = 0;

   always @(negedge clk)
      if (rst_n) begin
         if (out_valid) begin rxq.push_back(out_data); last_v = cyc; end
         if (frame_done) begin done_n++; done_gap = cyc - last_v; end
      end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_bit(input logic b, input int w, input int g);
      @(posedge clk); #1;
      line_one = b ? 1'b0 : 1'b1;
      line_and = 1'b0;
      idle(w);
      line_and = 1'b1;
      line_one = 1'b1;
      idle(g);
   endtask

   task automatic pulse_rearm();
      @(posedge clk); #1 rearm = 1'b1;
      @(posedge clk); #1 rearm = 1'b0;
   endtask

   task automatic clear_mon();
      rxq.delete();
      done_n = 0;
   endtask

   function automatic logic [7:0] exp_byte(input logic b);
      return b ? 8'h31 : 8'h30;
   endfunction

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #(200000 * 8);
      n_bad++;
      $display("FAIL watchdog actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      logic bv[32];
      int n, lim, bad, notascii;
      void'($urandom(32'h5eed_1234));

      idle(4);
      @(negedge clk);
      chk("R12 out_valid", out_valid, 0);
      chk("R12 frame_done", frame_done, 0);
      chk("R12 overflow", overflow, 0);
      chk("R12 rx_open", rx_open, 0);
      rst_n = 1'b1;
      en = 1'b1;
      idle(3);
      @(negedge clk);
      chk("R12 rx_open follows en", rx_open, 1);

      // R6: open, no bits, long wait
      idle_limit = W'(20);
      clear_mon();
      idle(400);
      chk("R6 no done before first bit", done_n, 0);

      // random frames
      notascii = 0;
      for (int f = 0; f < 6; f++) begin
         n = 4 + int'($urandom % 23);
         lim = 30 + int'($urandom % 40);
         idle_limit = W'(lim);
         clear_mon();
         for (int i = 0; i < n; i++) begin
            bv[i] = 1'($urandom);
            send_bit(bv[i], 2 + int'($urandom % 8), 3 + int'($urandom % 23));
         end
         idle(2 * lim * P + 20);
         chk("R1 byte count", rxq.size(), n);
         bad = 0;
         for (int i = 0; i < n && i < rxq.size(); i++) begin
            if (rxq[i] != exp_byte(bv[i])) bad++;
            if (rxq[i] != 8'h30 && rxq[i] != 8'h31) notascii++;
         end
         chk("R2 byte values", bad, 0);
         chk("R5 one done per frame", done_n, 1);
         chk("R5 done distance", done_gap, lim * P);
         chk("R9 stays open", rx_open, 1);
      end
      chk("R3 ascii only", notascii, 0);

      // R4: minimum two-cycle levels
      idle_limit = W'(40);
      clear_mon();
      for (int i = 0; i < 8; i++) begin
         bv[i] = 1'(i % 3 == 0);
         send_bit(bv[i], 2, 2);
      end
      idle(40 * P + 20);
      bad = (rxq.size() == 8) ? 0 : 1;
      for (int i = 0; i < 8 && i < rxq.size(); i++)
         if (rxq[i] != exp_byte(bv[i])) bad++;
      chk("R4 fast stream", bad, 0);

      // R7: timeout disabled
      idle_limit = '0;
      clear_mon();
      send_bit(1'b1, 3, 3);
      idle(600);
      chk("R7 no done with limit 0", done_n, 0);
      chk("R7 bit delivered", rxq.size(), 1);

      // R11: disabled
      en = 1'b0;
      clear_mon();
      idle(2);
      @(negedge clk);
      chk("R11 rx_open low", rx_open, 0);
      send_bit(1'b0, 3, 5);
      send_bit(1'b1, 3, 5);
      idle(10);
      chk("R11 no bytes", rxq.size(), 0);
      en = 1'b1;

      // R8: auto-close
      auto_close = 1'b1;
      idle_limit = W'(20);
      clear_mon();
      send_bit(1'b1, 3, 4);
      send_bit(1'b0, 3, 4);
      send_bit(1'b1, 3, 4);
      idle(20 * P + 20);
      chk("R8 done seen", done_n, 1);
      @(negedge clk);
      chk("R8 closed", rx_open, 0);
      send_bit(1'b0, 3, 4);
      send_bit(1'b1, 3, 4);
      idle(6);
      chk("R8 ignored while closed", rxq.size(), 3);
      pulse_rearm();
      @(negedge clk);
      chk("R8 reopened", rx_open, 1);
      send_bit(1'b1, 3, 6);
      chk("R8 bit after rearm", rxq.size(), 4);
      if (rxq.size() == 4) chk("R8 value after rearm", rxq[3], 8'h31);
      auto_close = 1'b0;
      idle(20 * P + 20);

      // R10: overflow
      clear_mon();
      out_ready = 1'b0;
      send_bit(1'b1, 3, 6);
      @(negedge clk);
      chk("R10 dropped", rxq.size(), 0);
      chk("R10 overflow set", overflow, 1);
      out_ready = 1'b1;
      send_bit(1'b0, 3, 6);
      @(negedge clk);
      chk("R10 next bit delivered", rxq.size(), 1);
      chk("R10 overflow sticky", overflow, 1);
      pulse_rearm();
      @(negedge clk);
      chk("R10 overflow cleared", overflow, 0);

      summary();
      $finish;
   end
endmodule